// File: doc/BRIEF.md
# Priority Match-Rewrite Loopback Counter

This block is a single-switch packet engine with one ingress port, one egress port and an internal loopback path. A packet carries an N-field header with one bit per field. A table of ternary rules is searched on every pass. Each rule matches on the arrival port and on the header bits, and each header bit can be an exact value or a wildcard. The first matching rule in table order rewrites selected header bits and then either sends the packet back round the loopback or sends it out on egress.

When the table holds the binary-counter rule set, the header itself is the counter. A packet is zeroed on arrival and then circulates. Each pass turns the lowest zero field into a one and clears all the ones below it. The packet leaves once every field is one. The rules, not an adder, produce the count. A pass counter is also exposed so the number of loop passes can be checked from outside.

Top module: `lbc_loop_counter`

## Requirements
- R1: After reset, in_ready_o is 1, busy_o is 0, out_valid_o is 0, pass_cnt_o is 0 and every rule is invalid, so a packet offered to the empty table is dropped without an egress pulse.
- R2: A table write (cfg_we_i) takes effect only while busy_o is 0. A write presented while a packet is circulating is discarded and leaves that packet's trajectory and later lookups unchanged.
- R3: When several valid rules match, the rule with the lowest index wins. An invalid rule never matches.
- R4: A rule matches when its valid bit is set, its port condition holds (port_care 0, or arrival port equal to port_ingress, where 1 means ingress and 0 means loopback), and every header bit whose care bit is 1 equals the match bit.
- R5: The winning rule replaces each header bit whose rewrite-mask bit is 1 with the rewrite-value bit. All other bits keep their values.
- R6: A winning rule with fwd_out 1 raises out_valid_o for one cycle, one clock after the pass, with the rewritten header on out_hdr_o. The engine is then idle. With fwd_out 0 the rewritten header becomes hdr_o and is looked up again on the next clock with arrival port loopback.
- R7: While a packet circulates (busy_o 1), in_ready_o is 0 and in_valid_i/in_hdr_i have no effect.
- R8: A pass on which no rule matches discards the packet: the engine goes idle with no egress pulse.
- R9: pass_cnt_o is cleared when an ingress packet is accepted and rises by one on every loopback pass, including the final pass that exits or drops.
- R10: With the counter rule set loaded (index 0: ingress, clear all, loop; index 1: loopback all ones, out; then for k = N-1 down to 0, loopback header with bit k 0 and bits below it 1, set bit k and clear the lower bits, loop), a packet makes exactly 2^N passes. hdr_o runs 0, 1, 2, ... 2^N-1, and the egress header is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Table write strobe, honoured only when idle |
| cfg_idx_i | input | IDX_W | Rule index to write (0 = highest priority) |
| cfg_valid_i | input | 1 | Rule enable |
| cfg_port_care_i | input | 1 | 1: rule checks the arrival port |
| cfg_port_ingress_i | input | 1 | Required arrival port (1 ingress, 0 loopback) |
| cfg_match_i | input | N_FIELDS | Match bits |
| cfg_care_i | input | N_FIELDS | 1 = exact compare, 0 = wildcard |
| cfg_rw_val_i | input | N_FIELDS | Rewrite values |
| cfg_rw_mask_i | input | N_FIELDS | 1 = rewrite this bit |
| cfg_fwd_out_i | input | 1 | 1: send to egress, 0: loop |
| in_valid_i | input | 1 | Ingress packet present |
| in_hdr_i | input | N_FIELDS | Ingress header |
| in_ready_o | output | 1 | Engine can take an ingress packet |
| busy_o | output | 1 | A packet is circulating |
| hdr_o | output | N_FIELDS | Header of the circulating packet |
| pass_cnt_o | output | CNT_W | Loopback passes since the last accept |
| out_valid_o | output | 1 | Egress pulse |
| out_hdr_o | output | N_FIELDS | Egress header |

## Verification
Any fault in the table, in priority resolution or in the rewrite changes the circulating header. That change shows on hdr_o on the very next clock, so the header sequence is compared pass by pass against a bench-side model of the rules. A wrong stored rule or a mis-resolved priority appears as a skipped or repeated count value, or as an early or missing egress pulse. A leaked table write or a leaked ingress packet during circulation changes the final pass count away from 2^N. Random rule tables and random headers also exercise the wildcard, port-match and partial-mask paths, and each is checked against the modelled egress header, pass count or drop.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef enum logic {
    PORT_LOOP    = 1'b0,
    PORT_INGRESS = 1'b1
  } port_e;
endpackage

// File: rtl/lbc_rule_table.sv
module lbc_rule_table #(
  parameter int N_FIELDS = 4,
  parameter int N_RULES  = 8,
  localparam int IDX_W   = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    widx_i,
  input  logic                w_valid_i,
  input  logic                w_port_care_i,
  input  logic                w_port_ingress_i,
  input  logic [N_FIELDS-1:0] w_match_i,
  input  logic [N_FIELDS-1:0] w_care_i,
  input  logic [N_FIELDS-1:0] w_rw_val_i,
  input  logic [N_FIELDS-1:0] w_rw_mask_i,
  input  logic                w_fwd_out_i,
  input  logic                look_port_i,
  input  logic [N_FIELDS-1:0] look_hdr_i,
  output logic [N_RULES-1:0]  hit_o,
  input  logic [IDX_W-1:0]    sel_idx_i,
  output logic [N_FIELDS-1:0] sel_rw_val_o,
  output logic [N_FIELDS-1:0] sel_rw_mask_o,
  output logic                sel_fwd_out_o
);
  logic                valid_q   [N_RULES];
  logic                pcare_q   [N_RULES];
  logic                pin_q     [N_RULES];
  logic [N_FIELDS-1:0] match_q   [N_RULES];
  logic [N_FIELDS-1:0] care_q    [N_RULES];
  logic [N_FIELDS-1:0] rw_val_q  [N_RULES];
  logic [N_FIELDS-1:0] rw_mask_q [N_RULES];
  logic                fwd_q     [N_RULES];

  for (genvar r = 0; r < N_RULES; r++) begin : g_rule
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[r]   <= 1'b0;
        pcare_q[r]   <= 1'b0;
        pin_q[r]     <= 1'b0;
        match_q[r]   <= '0;
        care_q[r]    <= '0;
        rw_val_q[r]  <= '0;
        rw_mask_q[r] <= '0;
        fwd_q[r]     <= 1'b0;
      end else if (we_i && (widx_i == IDX_W'(r))) begin
        valid_q[r]   <= w_valid_i;
        pcare_q[r]   <= w_port_care_i;
        pin_q[r]     <= w_port_ingress_i;
        match_q[r]   <= w_match_i;
        care_q[r]    <= w_care_i;
        rw_val_q[r]  <= w_rw_val_i;
        rw_mask_q[r] <= w_rw_mask_i;
        fwd_q[r]     <= w_fwd_out_i;
      end
    end

    // ternary compare: care bit 0 is a wildcard
    assign hit_o[r] = valid_q[r]
                    && (!pcare_q[r] || (pin_q[r] == look_port_i))
                    && (((look_hdr_i ^ match_q[r]) & care_q[r]) == '0);
  end

  assign sel_rw_val_o  = rw_val_q[sel_idx_i];
  assign sel_rw_mask_o = rw_mask_q[sel_idx_i];
  assign sel_fwd_out_o = fwd_q[sel_idx_i];
endmodule

// File: rtl/lbc_prio_pick.sv
module lbc_prio_pick #(
  parameter int N_RULES = 8,
  localparam int IDX_W  = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic [N_RULES-1:0] hit_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  // lowest index wins: scan downward so the last assignment is the smallest hit
  always_comb begin
    idx_o = '0;
    for (int r = N_RULES - 1; r >= 0; r--) begin
      if (hit_i[r]) idx_o = IDX_W'(r);
    end
  end
  assign any_o = |hit_i;
endmodule

// File: rtl/lbc_loop_counter.sv
module lbc_loop_counter #(
  parameter int N_FIELDS = 4,
  parameter int N_RULES  = 8,
  parameter int CNT_W    = 16,
  localparam int IDX_W   = (N_RULES > 1) ? $clog2(N_RULES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_idx_i,
  input  logic                cfg_valid_i,
  input  logic                cfg_port_care_i,
  input  logic                cfg_port_ingress_i,
  input  logic [N_FIELDS-1:0] cfg_match_i,
  input  logic [N_FIELDS-1:0] cfg_care_i,
  input  logic [N_FIELDS-1:0] cfg_rw_val_i,
  input  logic [N_FIELDS-1:0] cfg_rw_mask_i,
  input  logic                cfg_fwd_out_i,
  input  logic                in_valid_i,
  input  logic [N_FIELDS-1:0] in_hdr_i,
  output logic                in_ready_o,
  output logic                busy_o,
  output logic [N_FIELDS-1:0] hdr_o,
  output logic [CNT_W-1:0]    pass_cnt_o,
  output logic                out_valid_o,
  output logic [N_FIELDS-1:0] out_hdr_o
);
  import lbc_pkg::*;

  logic                busy_q;
  logic [N_FIELDS-1:0] hdr_q;
  logic [CNT_W-1:0]    pass_q;
  logic                out_valid_q;
  logic [N_FIELDS-1:0] out_hdr_q;

  logic                accept;
  logic                fire;
  port_e               look_port;
  logic [N_FIELDS-1:0] look_hdr;
  logic [N_RULES-1:0]  hit;
  logic                any_hit;
  logic [IDX_W-1:0]    win_idx;
  logic [N_FIELDS-1:0] rw_val;
  logic [N_FIELDS-1:0] rw_mask;
  logic                fwd_out;
  logic [N_FIELDS-1:0] next_hdr;

  assign accept    = in_valid_i && !busy_q;
  assign fire      = busy_q || accept;
  assign look_port = busy_q ? PORT_LOOP : PORT_INGRESS;
  assign look_hdr  = busy_q ? hdr_q : in_hdr_i;

  lbc_rule_table #(
    .N_FIELDS(N_FIELDS),
    .N_RULES (N_RULES)
  ) i_table (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .we_i            (cfg_we_i && !busy_q),
    .widx_i          (cfg_idx_i),
    .w_valid_i       (cfg_valid_i),
    .w_port_care_i   (cfg_port_care_i),
    .w_port_ingress_i(cfg_port_ingress_i),
    .w_match_i       (cfg_match_i),
    .w_care_i        (cfg_care_i),
    .w_rw_val_i      (cfg_rw_val_i),
    .w_rw_mask_i     (cfg_rw_mask_i),
    .w_fwd_out_i     (cfg_fwd_out_i),
    .look_port_i     (look_port),
    .look_hdr_i      (look_hdr),
    .hit_o           (hit),
    .sel_idx_i       (win_idx),
    .sel_rw_val_o    (rw_val),
    .sel_rw_mask_o   (rw_mask),
    .sel_fwd_out_o   (fwd_out)
  );

  lbc_prio_pick #(
    .N_RULES(N_RULES)
  ) i_prio (
    .hit_i(hit),
    .any_o(any_hit),
    .idx_o(win_idx)
  );

  assign next_hdr = (look_hdr & ~rw_mask) | (rw_val & rw_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      hdr_q       <= '0;
      pass_q      <= '0;
      out_valid_q <= 1'b0;
      out_hdr_q   <= '0;
    end else begin
      out_valid_q <= 1'b0;
      if (fire) begin
        pass_q <= busy_q ? pass_q + 1'b1 : '0;
        if (!any_hit) begin
          busy_q <= 1'b0;              // no rule: discard
        end else if (fwd_out) begin
          busy_q      <= 1'b0;
          out_valid_q <= 1'b1;
          out_hdr_q   <= next_hdr;
        end else begin
          busy_q <= 1'b1;
          hdr_q  <= next_hdr;
        end
      end
    end
  end

  assign in_ready_o  = !busy_q;
  assign busy_o      = busy_q;
  assign hdr_o       = hdr_q;
  assign pass_cnt_o  = pass_q;
  assign out_valid_o = out_valid_q;
  assign out_hdr_o   = out_hdr_q;
endmodule

// File: rtl/lbc_loop_counter_chk.sv
module lbc_loop_counter_chk #(
  parameter int N_FIELDS = 4,
  parameter int CNT_W    = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                busy_o,
  input logic [CNT_W-1:0]    pass_cnt_o,
  input logic                out_valid_o,
  input logic [N_FIELDS-1:0] out_hdr_o
);
  // R9
  pass_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> pass_cnt_o == $past(pass_cnt_o) + 1'b1);

  // R9
  accept_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> pass_cnt_o == '0);

  // R6
  out_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!busy_o && in_ready_o));

  // R6
  out_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(busy_o) || $past(in_valid_i && in_ready_o)));

  // R7
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> pass_cnt_o != '0);
endmodule

bind lbc_loop_counter lbc_loop_counter_chk #(
  .N_FIELDS(N_FIELDS),
  .CNT_W   (CNT_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .busy_o     (busy_o),
  .pass_cnt_o (pass_cnt_o),
  .out_valid_o(out_valid_o),
  .out_hdr_o  (out_hdr_o)
);

// File: tb/test_lbc_loop_counter.sv
module test_lbc_loop_counter;
  localparam int N  = 4;
  localparam int NR = 8;
  localparam int CW = 16;
  localparam int IW = $clog2(NR);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [IW-1:0] cfg_idx_i = '0;
  logic          cfg_valid_i = 1'b0, cfg_port_care_i = 1'b0, cfg_port_ingress_i = 1'b0;
  logic [N-1:0]  cfg_match_i = '0, cfg_care_i = '0, cfg_rw_val_i = '0, cfg_rw_mask_i = '0;
  logic          cfg_fwd_out_i = 1'b0;
  logic          in_valid_i = 1'b0;
  logic [N-1:0]  in_hdr_i = '0;
  logic          in_ready_o, busy_o, out_valid_o;
  logic [N-1:0]  hdr_o, out_hdr_o;
  logic [CW-1:0] pass_cnt_o;

  lbc_loop_counter #(.N_FIELDS(N), .N_RULES(NR), .CNT_W(CW)) i_lbc_loop_counter (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench copy of the table
  bit           t_valid[NR], t_pcare[NR], t_pin[NR], t_fwd[NR];
  logic [N-1:0] t_match[NR], t_care[NR], t_rwv[NR], t_rwm[NR];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_rule(input int idx, input bit v, input bit pc, input bit pi,
                         input logic [N-1:0] m, input logic [N-1:0] c,
                         input logic [N-1:0] rv, input logic [N-1:0] rm, input bit f);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_idx_i = IW'(idx); cfg_valid_i = v; cfg_port_care_i = pc;
    cfg_port_ingress_i = pi; cfg_match_i = m; cfg_care_i = c; cfg_rw_val_i = rv;
    cfg_rw_mask_i = rm; cfg_fwd_out_i = f;
    @(negedge clk_i);
    cfg_we_i = 0;
    t_valid[idx] = v; t_pcare[idx] = pc; t_pin[idx] = pi; t_match[idx] = m;
    t_care[idx] = c; t_rwv[idx] = rv; t_rwm[idx] = rm; t_fwd[idx] = f;
  endtask

  task automatic clear_table();
    for (int r = 0; r < NR; r++) wr_rule(r, 0, 0, 0, '0, '0, '0, '0, 0);
  endtask

  task automatic load_counter();
    clear_table();
    wr_rule(0, 1, 1, 1, '0, '0, '0, '1, 0);
    wr_rule(1, 1, 1, 0, '1, '1, '0, '0, 1);
    for (int k = N - 1; k >= 0; k--) begin
      logic [N-1:0] low, m, c, rm;
      low = N'((1 << k) - 1);
      m = low; c = low | N'(1 << k); rm = c;
      wr_rule(2 + (N - 1 - k), 1, 1, 0, m, c, N'(1 << k), rm, 0);
    end
  endtask

  function automatic void model_run(input logic [N-1:0] h_in, output bit out,
                                    output logic [N-1:0] oh, output int passes,
                                    output bit term);
    logic [N-1:0] h, nh;
    bit port;
    int w;
    h = h_in; port = 1; passes = 0; out = 0; oh = '0; term = 0;
    for (int step = 0; step < 40; step++) begin
      if (!port) passes++;
      w = -1;
      for (int r = NR - 1; r >= 0; r--)
        if (t_valid[r] && (!t_pcare[r] || t_pin[r] == port) &&
            (((h ^ t_match[r]) & t_care[r]) == '0)) w = r;
      if (w < 0) begin term = 1; return; end
      nh = (h & ~t_rwm[w]) | (t_rwv[w] & t_rwm[w]);
      if (t_fwd[w]) begin out = 1; oh = nh; term = 1; return; end
      h = nh; port = 0;
    end
  endfunction

  // poke: 0 none, 1 ingress during busy, 2 table write during busy; seq: check counter sequence
  task automatic run_pkt(input logic [N-1:0] h, input int poke, input bit seq,
                         output bit out, output logic [N-1:0] oh, output int passes);
    int cyc;
    out = 0; oh = '0; passes = 0; cyc = 0;
    @(negedge clk_i);
    in_valid_i = 1; in_hdr_i = h;
    @(negedge clk_i);
    in_valid_i = 0;
    while (1) begin
      if (out_valid_o) begin
        out = 1; oh = out_hdr_o; passes = int'(pass_cnt_o); break;
      end
      if (!busy_o) begin passes = int'(pass_cnt_o); break; end
      if (seq) chk(hdr_o == pass_cnt_o[N-1:0], "R10 sequence", hdr_o, pass_cnt_o[N-1:0]);
      if (poke != 0 && cyc < 3) begin
        if (cyc == 0) chk(in_ready_o == 0, "R7 ready low while busy", in_ready_o, 0);
        if (poke == 1) begin in_valid_i = 1; in_hdr_i = 4'hA; end
        if (poke == 2) begin
          cfg_we_i = 1; cfg_idx_i = IW'(2); cfg_valid_i = 1; cfg_port_care_i = 0;
          cfg_care_i = '0; cfg_rw_mask_i = '0; cfg_fwd_out_i = 1;
        end
      end else begin
        in_valid_i = 0; cfg_we_i = 0;
      end
      cyc++;
      @(negedge clk_i);
    end
    in_valid_i = 0; cfg_we_i = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit o, e_o, term;
    logic [N-1:0] oh, e_oh;
    int p, e_p;
    void'($urandom(32'h5EED));
    for (int r = 0; r < NR; r++) begin
      t_valid[r] = 0; t_pcare[r] = 0; t_pin[r] = 0; t_fwd[r] = 0;
      t_match[r] = '0; t_care[r] = '0; t_rwv[r] = '0; t_rwm[r] = '0;
    end
    #45 rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk(in_ready_o == 1, "R1 ready", in_ready_o, 1);
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(out_valid_o == 0, "R1 out_valid", out_valid_o, 0);
    chk(pass_cnt_o == 0, "R1 pass_cnt", pass_cnt_o, 0);
    run_pkt(4'h6, 0, 0, o, oh, p);
    chk(o == 0, "R1 empty table drops", o, 0);
    chk(in_ready_o == 1, "R8 idle after drop", in_ready_o, 1);

    // R10 counter, several ingress headers
    load_counter();
    for (int i = 0; i < 3; i++) begin
      run_pkt(N'(i * 5 + 3), 0, 1, o, oh, p);
      chk(o == 1, "R10 egress", o, 1);
      chk(oh == '1, "R10 egress all ones", oh, '1);
      chk(p == (1 << N), "R10 R9 pass count", p, 1 << N);
    end

    // R7 ingress ignored while busy
    run_pkt(4'h0, 1, 1, o, oh, p);
    chk(p == (1 << N) && oh == '1, "R7 busy ingress ignored", p, 1 << N);
    // R2 write while busy discarded
    run_pkt(4'h0, 2, 1, o, oh, p);
    chk(p == (1 << N), "R2 busy write ignored", p, 1 << N);
    run_pkt(4'h9, 0, 1, o, oh, p);
    chk(p == (1 << N) && oh == '1, "R2 table intact", p, 1 << N);

    // R3 priority, R6 direct egress from ingress
    clear_table();
    wr_rule(0, 1, 0, 0, '0, '0, 4'h3, '1, 1);
    wr_rule(1, 1, 0, 0, '0, '0, 4'hC, '1, 1);
    run_pkt(4'h0, 0, 0, o, oh, p);
    chk(o && oh == 4'h3, "R3 lowest index wins", oh, 4'h3);
    chk(p == 0, "R9 no passes on direct egress", p, 0);
    wr_rule(0, 0, 0, 0, '0, '0, 4'h3, '1, 1);
    run_pkt(4'h0, 0, 0, o, oh, p);
    chk(o && oh == 4'hC, "R3 invalid rule skipped", oh, 4'hC);

    // R4 port match, R5 partial rewrite
    clear_table();
    wr_rule(0, 1, 1, 0, '0, '0, 4'hF, '1, 1);
    wr_rule(1, 1, 1, 1, 4'b1000, 4'b1000, 4'b1111, 4'b0101, 1);
    run_pkt(4'b1000, 0, 0, o, oh, p);
    chk(o && oh == 4'b1101, "R4 R5 port and mask", oh, 4'b1101);
    run_pkt(4'b0000, 0, 0, o, p == 0 ? oh : oh, p);
    chk(o == 0, "R8 R4 care mismatch drops", o, 0);

    // random tables vs model (R3 R4 R5 R6 R8 R9)
    for (int t = 0; t < 40; t++) begin
      clear_table();
      for (int r = 0; r < NR; r++)
        wr_rule(r, ($urandom % 4) != 0, $urandom % 2, $urandom % 2, N'($urandom),
                N'($urandom), N'($urandom), N'($urandom), ($urandom % 3) == 0);
      for (int k = 0; k < 4; k++) begin
        logic [N-1:0] h;
        h = N'($urandom);
        model_run(h, e_o, e_oh, e_p, term);
        if (!term) continue;
        run_pkt(h, 0, 0, o, oh, p);
        chk(o == e_o, "R6 R8 random egress flag", o, e_o);
        if (e_o) chk(oh == e_oh, "R5 random egress header", oh, e_oh);
        chk(p == e_p, "R9 random pass count", p, e_p);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule